// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block turns activity on seventeen input pins into interrupt requests for a processor core. One pin is a dedicated external interrupt line with a selectable sense mode. The other sixteen are general I/O pins split into a lower group and an upper group of eight. Each group has an 8-bit mask that picks which of its pins can report a change. Every input passes through a two-flop synchronizer. A third register stage holds the previous value, so rises, falls and toggles can be found.

A byte-wide register bus gives software five registers:

| Register | Address | Contents |
|---|---|---|
| Lower-group mask | 0x12 | one enable bit per lower-group pin |
| Upper-group mask | 0x20 | one enable bit per upper-group pin |
| Source enable | 0x3B | external at bit 6, upper group at bit 5, lower group at bit 4 |
| Flag | 0x3A | same bit positions as the source enable register |
| Sense mode | 0x35 | bits 1:0 |

The core supplies a global interrupt enable. The block returns a request line and a 2-bit code for the source with the highest priority. When the core takes that vector it pulses an acknowledge input, and only the served flag is cleared.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every register reads 0x00, `irq_req` is 0 and `irq_src` is 3 (no source).
- R2: The lower-group mask at address 0x12 and the upper-group mask at address 0x20 are fully read/write bytes.
- R3: A toggle on a lower-group pin whose mask bit is 1 sets flag bit 4 on the third rising clock edge after the pin changes (two synchronizer stages, then one compare stage).
- R4: A toggle on an upper-group pin whose mask bit is 1 sets flag bit 5. A toggle on a pin whose mask bit is 0 sets no flag. Setting a mask bit for a pin that is held steady sets no flag.
- R5: The sense register bits 1:0 select the external pin mode: 00 low level, 01 any change, 10 falling edge, 11 rising edge. In modes 01, 10 and 11 a matching transition sets flag bit 6, and any other transition leaves it clear.
- R6: In sense mode 00, flag bit 6 reads 0, and a flag that was set earlier reads 0 once the mode is written. If the external enable and the global enable are both set, `irq_req` follows the synchronized pin being low, two clock edges after the pin changes, with `irq_src` = 0.
- R7: Writing to the flag register clears each flag whose written bit is 1. Flags written with 0 keep their value.
- R8: A source requests only when `global_ie` is 1, its flag is set (or, for the external pin in mode 00, the pin is low), and its enable bit in register 0x3B is 1.
- R9: When several sources request at once, `irq_src` gives the highest-priority one. The order is external pin (code 0), then lower group (code 1), then upper group (code 2). Code 3 means no request.
- R10: A one-cycle `irq_ack` while `irq_req` is 1 clears only the flag of the source shown on `irq_src`.
- R11: If a new event arrives in the same cycle as a clear of its flag, either by write or by acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| pin_lo | input | 8 | Lower-group I/O pins (asynchronous) |
| pin_hi | input | 8 | Upper-group I/O pins (asynchronous) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| global_ie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Vector-taken pulse from the core |
| irq_req | output | 1 | Interrupt request |
| irq_src | output | 2 | Code of the source being requested |

## Verification
The assertions check these behaviours on every cycle:
- no request is made without the global enable;
- the priority order holds between pending sources;
- an acknowledge clears only the flag it served;
- a write of one clears its flag;
- a new event wins over a clear in the same cycle;
- flag bit 6 is zero in level mode.

Some behaviours can only be shown by the bench's scenarios, because they depend on the pins and on the expected results:
- the exact three-edge latency through the synchronizer;
- which transitions each sense mode accepts;
- the per-pin masking of random toggle patterns;
- the two-edge tracking of the level request.

// File: rtl/pei_pkg.sv
package pei_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int GRP_W    = DATA_W;
    localparam int N_GRP    = 2;
    localparam int SYNC_W   = 1 + N_GRP * GRP_W;
    localparam int SRC_W    = 2;

    localparam logic [ADDR_W-1:0] ADR_MASK_LO = 8'h12;
    localparam logic [ADDR_W-1:0] ADR_MASK_HI = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_SENSE   = 8'h35;
    localparam logic [ADDR_W-1:0] ADR_FLAG    = 8'h3A;
    localparam logic [ADDR_W-1:0] ADR_SRC_EN  = 8'h3B;

    localparam int BIT_EXT = 6;
    localparam int BIT_G1  = 5;
    localparam int BIT_G0  = 4;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT  = 2'd0,
        SRC_G0   = 2'd1,
        SRC_G1   = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        logic ext;
        logic g1;
        logic g0;
    } src_vec_t;

    localparam src_vec_t SRC_VEC_ZERO = '{ext: 1'b0, g1: 1'b0, g0: 1'b0};

    // Qualify a transition of the external pin under the selected mode
    function automatic logic ext_event(sense_e mode, logic cur, logic prev);
        logic hit;
        unique case (mode)
            SNS_ANY:  hit = cur ^ prev;
            SNS_FALL: hit = prev & ~cur;
            SNS_RISE: hit = cur & ~prev;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Place a per-source vector at its register bit positions
    function automatic logic [DATA_W-1:0] src_to_byte(src_vec_t v);
        logic [DATA_W-1:0] b;
        b          = '0;
        b[BIT_EXT] = v.ext;
        b[BIT_G1]  = v.g1;
        b[BIT_G0]  = v.g0;
        return b;
    endfunction

    function automatic src_vec_t byte_to_src(logic [DATA_W-1:0] b);
        src_vec_t v;
        v.ext = b[BIT_EXT];
        v.g1  = b[BIT_G1];
        v.g0  = b[BIT_G0];
        return v;
    endfunction

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] stage3;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
                stage3[i] <= 1'b0;
            end else begin
                stage1[i] <= din[i];
                stage2[i] <= stage1[i];
                stage3[i] <= stage2[i];
            end
        end
    end

    assign cur  = stage2;
    assign prev = stage3;
endmodule

// File: rtl/pei_detect.sv
module pei_detect
    import pei_pkg::*;
(
    input  logic                        ext_cur,
    input  logic                        ext_prev,
    input  logic [N_GRP-1:0][GRP_W-1:0] grp_cur,
    input  logic [N_GRP-1:0][GRP_W-1:0] grp_prev,
    input  logic [N_GRP-1:0][GRP_W-1:0] masks,
    input  sense_e                      sense,
    output src_vec_t                    ev
);
    logic [N_GRP-1:0] grp_hit;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_hit[g] = |((grp_cur[g] ^ grp_prev[g]) & masks[g]);
    end

    always_comb begin
        ev.ext = ext_event(sense, ext_cur, ext_prev);
        ev.g0  = grp_hit[0];
        ev.g1  = grp_hit[1];
    end
endmodule

// File: rtl/pei_regs.sv
module pei_regs
    import pei_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  src_vec_t                    ev,
    input  src_vec_t                    ack_clr,
    output logic [N_GRP-1:0][GRP_W-1:0] masks,
    output src_vec_t                    src_en,
    output sense_e                      sense,
    output src_vec_t                    flags
);
    logic [N_GRP-1:0][GRP_W-1:0] masks_q;
    src_vec_t                    en_q;
    sense_e                      sense_q;
    sense_e                      sense_n;
    src_vec_t                    flags_q;
    src_vec_t                    flags_n;
    src_vec_t                    w1c;
    logic                        wr_mask_lo;
    logic                        wr_mask_hi;
    logic                        wr_en;
    logic                        wr_sense;
    logic                        wr_flag;

    assign wr_mask_lo = bus_wr && (bus_addr == ADR_MASK_LO);
    assign wr_mask_hi = bus_wr && (bus_addr == ADR_MASK_HI);
    assign wr_en      = bus_wr && (bus_addr == ADR_SRC_EN);
    assign wr_sense   = bus_wr && (bus_addr == ADR_SENSE);
    assign wr_flag    = bus_wr && (bus_addr == ADR_FLAG);

    always_comb begin
        sense_n = wr_sense ? sense_e'(bus_wdata[1:0]) : sense_q;
        w1c     = wr_flag ? byte_to_src(bus_wdata) : SRC_VEC_ZERO;
        // A new event outranks any clear in the same cycle
        flags_n.g0  = ev.g0  | (flags_q.g0  & ~w1c.g0  & ~ack_clr.g0);
        flags_n.g1  = ev.g1  | (flags_q.g1  & ~w1c.g1  & ~ack_clr.g1);
        flags_n.ext = ev.ext | (flags_q.ext & ~w1c.ext & ~ack_clr.ext);
        // The external flag is pinned low while level sensing is selected
        if (sense_n == SNS_LOW) begin
            flags_n.ext = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            masks_q <= '0;
            en_q    <= SRC_VEC_ZERO;
            sense_q <= SNS_LOW;
            flags_q <= SRC_VEC_ZERO;
        end else begin
            if (wr_mask_lo) masks_q[0] <= bus_wdata;
            if (wr_mask_hi) masks_q[1] <= bus_wdata;
            if (wr_en)      en_q       <= byte_to_src(bus_wdata);
            sense_q <= sense_n;
            flags_q <= flags_n;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_MASK_LO: bus_rdata = masks_q[0];
            ADR_MASK_HI: bus_rdata = masks_q[1];
            ADR_SRC_EN:  bus_rdata = src_to_byte(en_q);
            ADR_FLAG:    bus_rdata = src_to_byte(flags_q);
            ADR_SENSE:   bus_rdata = {{(DATA_W-2){1'b0}}, sense_q};
            default:     bus_rdata = '0;
        endcase
    end

    assign masks  = masks_q;
    assign src_en = en_q;
    assign sense  = sense_q;
    assign flags  = flags_q;
endmodule

// File: rtl/pei_arbiter.sv
module pei_arbiter
    import pei_pkg::*;
(
    input  src_vec_t         flags,
    input  src_vec_t         src_en,
    input  sense_e           sense,
    input  logic             ext_level,
    input  logic             global_ie,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [SRC_W-1:0] irq_src,
    output src_vec_t         ack_clr
);
    src_vec_t pend;
    src_e     pick;

    always_comb begin
        pend.ext = global_ie & src_en.ext &
                   ((sense == SNS_LOW) ? ~ext_level : flags.ext);
        pend.g0  = global_ie & src_en.g0 & flags.g0;
        pend.g1  = global_ie & src_en.g1 & flags.g1;

        if (pend.ext)     pick = SRC_EXT;
        else if (pend.g0) pick = SRC_G0;
        else if (pend.g1) pick = SRC_G1;
        else              pick = SRC_NONE;

        ack_clr     = SRC_VEC_ZERO;
        ack_clr.ext = irq_ack && (pick == SRC_EXT);
        ack_clr.g0  = irq_ack && (pick == SRC_G0);
        ack_clr.g1  = irq_ack && (pick == SRC_G1);
    end

    assign irq_req = (pick != SRC_NONE);
    assign irq_src = pick;
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pei_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic [GRP_W-1:0]  pin_lo,
    input  logic [GRP_W-1:0]  pin_hi,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              global_ie,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [SRC_W-1:0]  irq_src
);
    logic [SYNC_W-1:0]           s_cur;
    logic [SYNC_W-1:0]           s_prev;
    logic [N_GRP-1:0][GRP_W-1:0] grp_cur;
    logic [N_GRP-1:0][GRP_W-1:0] grp_prev;
    logic [N_GRP-1:0][GRP_W-1:0] masks;
    src_vec_t                    ev;
    src_vec_t                    ack_clr;
    src_vec_t                    src_en;
    src_vec_t                    flags;
    sense_e                      sense;

    pei_sync #(.W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({pin_hi, pin_lo, ext_pin}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    assign grp_cur  = s_cur[SYNC_W-1:1];
    assign grp_prev = s_prev[SYNC_W-1:1];

    pei_detect u_detect (
        .ext_cur  (s_cur[0]),
        .ext_prev (s_prev[0]),
        .grp_cur  (grp_cur),
        .grp_prev (grp_prev),
        .masks    (masks),
        .sense    (sense),
        .ev       (ev)
    );

    pei_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev        (ev),
        .ack_clr   (ack_clr),
        .masks     (masks),
        .src_en    (src_en),
        .sense     (sense),
        .flags     (flags)
    );

    pei_arbiter u_arb (
        .flags     (flags),
        .src_en    (src_en),
        .sense     (sense),
        .ext_level (s_cur[0]),
        .global_ie (global_ie),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .irq_src   (irq_src),
        .ack_clr   (ack_clr)
    );
endmodule

// File: rtl/pei_checker.sv
module pei_checker
    import pei_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              global_ie,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [SRC_W-1:0]  irq_src,
    input src_vec_t          flags,
    input src_vec_t          src_en,
    input sense_e            sense,
    input src_vec_t          ev
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flags == SRC_VEC_ZERO) && !irq_req);

    a_r8_no_req_without_gie: assert property (@(posedge clk) disable iff (rst)
        !global_ie |-> !irq_req);

    a_r9_ext_first: assert property (@(posedge clk) disable iff (rst)
        (global_ie && src_en.ext && flags.ext) |-> (irq_req && irq_src == SRC_EXT));

    a_r9_g0_over_g1: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_src == SRC_G1) |-> !(flags.g0 && src_en.g0));

    a_r10_ack_clears_g0: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && irq_src == SRC_G0 && !ev.g0) |=> !flags.g0);

    a_r10_ack_spares_g1: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && irq_src == SRC_G0 && flags.g1 && !bus_wr) |=> flags.g1);

    a_r7_w1c_g1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_FLAG && bus_wdata[BIT_G1] && !ev.g1) |=> !flags.g1);

    a_r11_event_wins_g0: assert property (@(posedge clk) disable iff (rst)
        ev.g0 |=> flags.g0);

    a_r11_event_wins_g1: assert property (@(posedge clk) disable iff (rst)
        ev.g1 |=> flags.g1);

    a_r6_level_flag_zero: assert property (@(posedge clk) disable iff (rst)
        (sense == SNS_LOW) |-> !flags.ext);
endmodule

bind pin_event_irq pei_checker i_pei_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .global_ie (global_ie),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_src   (irq_src),
    .flags     (flags),
    .src_en    (src_en),
    .sense     (sense),
    .ev        (ev)
);

// File: tb/test_pin_event_irq.sv
module test_pin_event_irq;
    import pei_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic [7:0] pin_lo = '0;
    logic [7:0] pin_hi = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       global_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [1:0] irq_src;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pin_event_irq i_pin_event_irq (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .pin_lo(pin_lo), .pin_hi(pin_hi),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .global_ie(global_ie), .irq_ack(irq_ack), .irq_req(irq_req), .irq_src(irq_src)
    );

    function automatic logic grp_expect(logic [7:0] a, logic [7:0] b, logic [7:0] m);
        return |((a ^ b) & m);
    endfunction

    function automatic logic ext_expect(logic [1:0] mode, logic a, logic b);
        case (mode)
            2'b01:   return a ^ b;
            2'b10:   return a & ~b;
            2'b11:   return ~a & b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        int unsigned seed;
        seed = $urandom(32'h5EED);
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        rd(ADR_MASK_LO, d); check("R1 mask_lo", d, 8'h00);
        rd(ADR_MASK_HI, d); check("R1 mask_hi", d, 8'h00);
        rd(ADR_SRC_EN, d);  check("R1 enable", d, 8'h00);
        rd(ADR_FLAG, d);    check("R1 flags", d, 8'h00);
        rd(ADR_SENSE, d);   check("R1 sense", d, 8'h00);
        check("R1 irq_req", {7'd0, irq_req}, 8'h00);
        check("R1 irq_src", {6'd0, irq_src}, 8'h03);

        // R2 mask read/write
        wr(ADR_MASK_LO, 8'hA5); wr(ADR_MASK_HI, 8'h3C);
        rd(ADR_MASK_LO, d); check("R2 mask_lo rw", d, 8'hA5);
        rd(ADR_MASK_HI, d); check("R2 mask_hi rw", d, 8'h3C);

        // R3 exact latency, lower group
        wr(ADR_MASK_LO, 8'h01);
        wr(ADR_FLAG, 8'h70);
        @(negedge clk); bus_addr = ADR_FLAG;
        pin_lo[0] = 1'b1;
        cyc(2); #1 check("R3 flag before third edge", bus_rdata & 8'h10, 8'h00);
        cyc(1); #1 check("R3 flag on third edge", bus_rdata & 8'h10, 8'h10);

        // R4 unmasked pin ignored, upper group, steady pin mask enable
        wr(ADR_FLAG, 8'h70);
        @(negedge clk); pin_lo[1] = 1'b1;
        cyc(4); rd(ADR_FLAG, d); check("R4 unmasked lower pin", d & 8'h10, 8'h00);
        wr(ADR_MASK_LO, 8'h03);
        cyc(3); rd(ADR_FLAG, d); check("R4 mask on steady pin", d & 8'h10, 8'h00);
        wr(ADR_MASK_HI, 8'h80);
        @(negedge clk); pin_hi[7] = 1'b1;
        cyc(4); rd(ADR_FLAG, d); check("R4 upper group flag", d & 8'h30, 8'h20);

        // R5 sense modes, directed
        wr(ADR_SENSE, 8'h03); wr(ADR_FLAG, 8'h70);
        @(negedge clk); ext_pin = 1'b1;
        cyc(4); rd(ADR_FLAG, d); check("R5 rise seen", d & 8'h40, 8'h40);
        wr(ADR_FLAG, 8'h40);
        @(negedge clk); ext_pin = 1'b0;
        cyc(4); rd(ADR_FLAG, d); check("R5 fall ignored in rise mode", d & 8'h40, 8'h00);
        wr(ADR_SENSE, 8'h02);
        @(negedge clk); ext_pin = 1'b1;
        cyc(4); rd(ADR_FLAG, d); check("R5 rise ignored in fall mode", d & 8'h40, 8'h00);

        // R6 level mode
        wr(ADR_SENSE, 8'h01);
        @(negedge clk); ext_pin = 1'b0;
        cyc(4); rd(ADR_FLAG, d); check("R6 any-mode flag set first", d & 8'h40, 8'h40);
        wr(ADR_SENSE, 8'h00);
        rd(ADR_FLAG, d); check("R6 flag zero in level mode", d & 8'h40, 8'h00);
        @(negedge clk); ext_pin = 1'b1;
        cyc(4);
        wr(ADR_SRC_EN, 8'h40); global_ie = 1'b1;
        @(negedge clk); ext_pin = 1'b0;
        cyc(1); check("R6 level req after one edge", {7'd0, irq_req}, 8'h00);
        cyc(1); check("R6 level req after two edges", {7'd0, irq_req}, 8'h01);
        check("R6 level src", {6'd0, irq_src}, 8'h00);
        rd(ADR_FLAG, d); check("R6 level flag reads zero", d & 8'h40, 8'h00);
        @(negedge clk); ext_pin = 1'b1;
        cyc(2); check("R6 level req released", {7'd0, irq_req}, 8'h00);
        global_ie = 1'b0;

        // R7 write-one-to-clear
        wr(ADR_FLAG, 8'h70);
        @(negedge clk); pin_lo[0] = ~pin_lo[0]; pin_hi[7] = ~pin_hi[7];
        cyc(4); rd(ADR_FLAG, d); check("R7 both group flags set", d, 8'h30);
        wr(ADR_FLAG, 8'h00); rd(ADR_FLAG, d); check("R7 zero write keeps", d, 8'h30);
        wr(ADR_FLAG, 8'h10); rd(ADR_FLAG, d); check("R7 one clears only g0", d, 8'h20);

        // R8 request gating
        @(negedge clk); pin_lo[0] = ~pin_lo[0];
        cyc(4);
        wr(ADR_SRC_EN, 8'h00); global_ie = 1'b1;
        cyc(1); check("R8 no enable no req", {7'd0, irq_req}, 8'h00);
        wr(ADR_SRC_EN, 8'h30); global_ie = 1'b0;
        cyc(1); check("R8 no gie no req", {7'd0, irq_req}, 8'h00);
        global_ie = 1'b1;
        cyc(1); check("R8 all set req", {7'd0, irq_req}, 8'h01);

        // R9 priority, R10 acknowledge
        wr(ADR_SENSE, 8'h01); wr(ADR_SRC_EN, 8'h70);
        @(negedge clk); ext_pin = ~ext_pin;
        cyc(4); rd(ADR_FLAG, d); check("R9 three flags", d, 8'h70);
        check("R9 ext wins", {6'd0, irq_src}, 8'h00);
        ack_pulse(); #1 check("R10 ack clears ext only", bus_rdata, 8'h30);
        check("R9 g0 next", {6'd0, irq_src}, 8'h01);
        ack_pulse(); #1 check("R10 ack clears g0 only", bus_rdata, 8'h20);
        check("R9 g1 last", {6'd0, irq_src}, 8'h02);
        ack_pulse(); #1 check("R10 ack clears g1", bus_rdata, 8'h00);
        check("R10 none left", {6'd0, irq_src}, 8'h03);

        // R11 event beats clear
        wr(ADR_SRC_EN, 8'h10);
        @(negedge clk); pin_lo[0] = ~pin_lo[0];
        cyc(4); rd(ADR_FLAG, d); check("R11 g0 preset", d & 8'h10, 8'h10);
        @(negedge clk); pin_lo[0] = ~pin_lo[0];
        cyc(2); bus_addr = ADR_FLAG; bus_wdata = 8'h10; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        #1 check("R11 event beats write clear", bus_rdata & 8'h10, 8'h10);
        @(negedge clk); pin_lo[0] = ~pin_lo[0];
        cyc(2); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1 check("R11 event beats ack clear", bus_rdata & 8'h10, 8'h10);
        wr(ADR_FLAG, 8'h10); rd(ADR_FLAG, d); check("R11 plain clear works", d & 8'h10, 8'h00);
        global_ie = 1'b0;

        // R4 random group patterns
        for (int i = 0; i < 24; i++) begin
            logic [7:0] m, a, b;
            logic       hi_grp;
            hi_grp = 1'($urandom);
            m = 8'($urandom); a = 8'($urandom); b = 8'($urandom);
            if (i % 4 == 0) b = a;
            wr(hi_grp ? ADR_MASK_HI : ADR_MASK_LO, m);
            @(negedge clk); if (hi_grp) pin_hi = a; else pin_lo = a;
            cyc(4); wr(ADR_FLAG, 8'h70);
            @(negedge clk); if (hi_grp) pin_hi = b; else pin_lo = b;
            cyc(4); rd(ADR_FLAG, d);
            if (hi_grp) check("R4 random upper", {7'd0, d[5]}, {7'd0, grp_expect(a, b, m)});
            else        check("R3 random lower", {7'd0, d[4]}, {7'd0, grp_expect(a, b, m)});
        end

        // R5 random sense patterns
        for (int i = 0; i < 16; i++) begin
            logic [1:0] mode;
            logic       a, b;
            mode = 2'(1 + ($urandom % 3));
            a = 1'($urandom); b = 1'($urandom);
            wr(ADR_SENSE, {6'd0, mode});
            @(negedge clk); ext_pin = a;
            cyc(4); wr(ADR_FLAG, 8'h70);
            @(negedge clk); ext_pin = b;
            cyc(4); rd(ADR_FLAG, d);
            check("R5 random sense", {7'd0, d[6]}, {7'd0, ext_expect(mode, a, b)});
        end

        done = 1'b1;
        summary();
    end
endmodule